// File: doc/BRIEF.md
# Paged Segmentation Address Translator

This block turns a virtual address into a physical address using a two-level scheme. The top bits choose one of a small set of segments. The middle bits choose a page within that segment. The low bits are carried through as the offset within the page. The segment table sits inside the block and is loaded through a one-cycle configuration write. Each segment entry holds the byte address of that segment's page table in memory, the number of pages the segment covers, and a flag that allows writes to the segment.

A translation request carries the virtual address and a read/write flag, and is accepted with a valid/ready handshake. The block first checks the page number against the segment length and checks the segment's write flag. A request that fails either check is answered with a fault and never reaches memory. A request that passes fetches one 32-bit page entry over a request/response read port. The block then checks the entry's valid and writable bits, and returns either the physical address or a 2-bit fault code. The result is held until the consumer takes it. Only one translation is in flight at a time.

The control is a five-state machine:
- `ST_IDLE`: accepts a request and moves to `ST_CHECK`.
- `ST_CHECK`: does the segment-level checks. On a fault it moves to `ST_DONE`; otherwise it moves to `ST_ISSUE`.
- `ST_ISSUE`: offers the page-entry read. It moves to `ST_WAIT` when memory is ready.
- `ST_WAIT`: waits for the read data and moves to `ST_DONE` when it arrives.
- `ST_DONE`: presents the result. It returns to `ST_IDLE` when the consumer accepts it.

Top module: `pst_translator`

## Requirements
- R1: The virtual address is split into the segment number in bits [31:28], the page number in bits [27:12] and the offset in bits [11:0].
- R2: A cycle with `cfg_we` high writes the base, length and write flag into segment `cfg_idx`. The new entry governs every request checked after that cycle.
- R3: When the page number is not below the segment length, the response has fault code 1 (bounds) and no memory read is issued.
- R4: A write to a segment whose write flag is 0 (and which passes the bounds check) gets fault code 2 (permission) with no memory read. The bounds check takes precedence over this check.
- R5: A request that passes the segment checks issues exactly one read, at address base + page*4.
- R6: When the page entry's valid bit (bit 1) is 0, the response has fault code 3 (invalid), whatever the access type.
- R7: A write through a valid page entry whose writable bit (bit 0) is 0 gets fault code 2.
- R8: A successful translation returns fault code 0 and a physical address made of page-entry bits [31:12] followed by the unchanged offset.
- R9: Every faulting response carries a physical address of zero.
- R10: While a result is pending or a read is outstanding, no new request is accepted. A response not yet accepted keeps its valid, address and fault unchanged.
- R11: After reset, `req_ready` is 1, `rsp_valid` and `mem_req_valid` are 0, and every segment has length 0, so any request faults with code 1.
- R12: A read request that is not yet accepted keeps `mem_req_valid` high with an unchanged address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Segment table write strobe |
| cfg_idx | input | 4 | Segment being written |
| cfg_base | input | 32 | Byte address of the segment's page table |
| cfg_len | input | 17 | Segment length in pages (0 to 65536) |
| cfg_wr_ok | input | 1 | 1 allows writes to the segment |
| req_valid | input | 1 | Translation request valid |
| req_ready | output | 1 | Block can accept a request |
| req_vaddr | input | 32 | Virtual address |
| req_write | input | 1 | 1 = write access, 0 = read access |
| mem_req_valid | output | 1 | Page-entry read request valid |
| mem_req_ready | input | 1 | Memory accepts the read |
| mem_req_addr | output | 32 | Byte address of the page entry |
| mem_rsp_valid | input | 1 | Read data valid |
| mem_rsp_data | input | 32 | Page entry read from memory |
| rsp_valid | output | 1 | Translation result valid |
| rsp_ready | input | 1 | Consumer accepts the result |
| rsp_paddr | output | 32 | Physical address (zero on a fault) |
| rsp_fault | output | 2 | 0 none, 1 bounds, 2 permission, 3 invalid entry |

## Verification
Requests sweep one segment across every page up to and past its length, alternating read and write with varied offsets, so that bounds, invalid-entry, page-permission and success outcomes are interleaved in one stream. A read-only segment shows the difference between a segment-level permission fault, which makes no read, and a page-level one, which does. An empty segment, an unconfigured segment and the largest page number of a full-size segment probe the length comparison at both ends. Reprogramming segments after traffic shows that a new length or write flag changes the outcome of the same address. Throughout, the memory side stalls its ready and varies its latency, and the consumer stalls its ready, so hold behaviour is separated from plain forwarding.

// File: rtl/pst_pkg.sv
package pst_pkg;

    typedef enum logic [1:0] {
        FLT_NONE    = 2'd0,
        FLT_BOUND   = 2'd1,
        FLT_PERM    = 2'd2,
        FLT_INVALID = 2'd3
    } fault_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CHECK,
        ST_ISSUE,
        ST_WAIT,
        ST_DONE
    } state_e;

    localparam int PTE_VALID_BIT = 1;
    localparam int PTE_WRITE_BIT = 0;

endpackage

// File: rtl/pst_seg_table.sv
module pst_seg_table #(
    parameter int SEG_W = 4,
    parameter int AW    = 32,
    parameter int LEN_W = 17
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [SEG_W-1:0] wr_idx,
    input  logic [AW-1:0]    wr_base,
    input  logic [LEN_W-1:0] wr_len,
    input  logic             wr_rw,
    input  logic [SEG_W-1:0] rd_idx,
    output logic [AW-1:0]    rd_base,
    output logic [LEN_W-1:0] rd_len,
    output logic             rd_rw
);
    localparam int NSEG = 1 << SEG_W;

    logic [AW-1:0]    base_q [NSEG];
    logic [LEN_W-1:0] len_q  [NSEG];
    logic             rw_q   [NSEG];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NSEG; i++) begin
                base_q[i] <= '0;
                len_q[i]  <= '0;
                rw_q[i]   <= 1'b0;
            end
        end else if (wr_en) begin
            base_q[wr_idx] <= wr_base;
            len_q[wr_idx]  <= wr_len;
            rw_q[wr_idx]   <= wr_rw;
        end
    end

    assign rd_base = base_q[rd_idx];
    assign rd_len  = len_q[rd_idx];
    assign rd_rw   = rw_q[rd_idx];

endmodule

// File: rtl/pst_seg_check.sv
module pst_seg_check
    import pst_pkg::*;
#(
    parameter int PG_W   = 16,
    parameter int LEN_W  = 17,
    parameter int AW     = 32,
    parameter int PTE_SH = 2
) (
    input  logic [PG_W-1:0]  page,
    input  logic [LEN_W-1:0] seg_len,
    input  logic             seg_rw,
    input  logic [AW-1:0]    seg_base,
    input  logic             is_write,
    output fault_e           fault,
    output logic [AW-1:0]    pte_addr
);
    logic in_range;

    assign in_range = LEN_W'(page) < seg_len;
    assign pte_addr = seg_base + (AW'(page) << PTE_SH);

    always_comb begin
        if (!in_range)
            fault = FLT_BOUND;
        else if (is_write && !seg_rw)
            fault = FLT_PERM;
        else
            fault = FLT_NONE;
    end

endmodule

// File: rtl/pst_pte_check.sv
module pst_pte_check
    import pst_pkg::*;
#(
    parameter int DW    = 32,
    parameter int OFF_W = 12
) (
    input  logic [DW-1:0]    pte,
    input  logic             is_write,
    input  logic [OFF_W-1:0] offset,
    output fault_e           fault,
    output logic [DW-1:0]    paddr
);
    assign paddr = {pte[DW-1:OFF_W], offset};

    always_comb begin
        if (!pte[PTE_VALID_BIT])
            fault = FLT_INVALID;
        else if (is_write && !pte[PTE_WRITE_BIT])
            fault = FLT_PERM;
        else
            fault = FLT_NONE;
    end

endmodule

// File: rtl/pst_translator.sv
module pst_translator
    import pst_pkg::*;
#(
    parameter int SEG_W = 4,
    parameter int PG_W  = 16,
    parameter int OFF_W = 12,
    parameter int AW    = 32,
    parameter int DW    = 32
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         cfg_we,
    input  logic [SEG_W-1:0]             cfg_idx,
    input  logic [AW-1:0]                cfg_base,
    input  logic [PG_W:0]                cfg_len,
    input  logic                         cfg_wr_ok,
    input  logic                         req_valid,
    output logic                         req_ready,
    input  logic [SEG_W+PG_W+OFF_W-1:0]  req_vaddr,
    input  logic                         req_write,
    output logic                         mem_req_valid,
    input  logic                         mem_req_ready,
    output logic [AW-1:0]                mem_req_addr,
    input  logic                         mem_rsp_valid,
    input  logic [DW-1:0]                mem_rsp_data,
    output logic                         rsp_valid,
    input  logic                         rsp_ready,
    output logic [DW-1:0]                rsp_paddr,
    output logic [1:0]                   rsp_fault
);
    localparam int VA_W   = SEG_W + PG_W + OFF_W;
    localparam int LEN_W  = PG_W + 1;
    localparam int PTE_SH = $clog2(DW / 8);

    state_e           state_q, state_d;
    logic [VA_W-1:0]  va_q;
    logic             wr_q;
    logic [AW-1:0]    pte_addr_q;
    logic [DW-1:0]    paddr_q;
    fault_e           fault_q;

    logic [SEG_W-1:0] va_seg;
    logic [PG_W-1:0]  va_page;
    logic [OFF_W-1:0] va_off;

    assign va_seg  = va_q[VA_W-1 -: SEG_W];
    assign va_page = va_q[OFF_W +: PG_W];
    assign va_off  = va_q[OFF_W-1:0];

    logic [AW-1:0]    seg_base;
    logic [LEN_W-1:0] seg_len;
    logic             seg_rw;
    fault_e           seg_fault;
    logic [AW-1:0]    seg_pte_addr;
    fault_e           pte_fault;
    logic [DW-1:0]    pte_paddr;

    pst_seg_table #(.SEG_W(SEG_W), .AW(AW), .LEN_W(LEN_W)) u_table (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (cfg_we),
        .wr_idx  (cfg_idx),
        .wr_base (cfg_base),
        .wr_len  (cfg_len),
        .wr_rw   (cfg_wr_ok),
        .rd_idx  (va_seg),
        .rd_base (seg_base),
        .rd_len  (seg_len),
        .rd_rw   (seg_rw)
    );

    pst_seg_check #(.PG_W(PG_W), .LEN_W(LEN_W), .AW(AW), .PTE_SH(PTE_SH)) u_seg_chk (
        .page     (va_page),
        .seg_len  (seg_len),
        .seg_rw   (seg_rw),
        .seg_base (seg_base),
        .is_write (wr_q),
        .fault    (seg_fault),
        .pte_addr (seg_pte_addr)
    );

    pst_pte_check #(.DW(DW), .OFF_W(OFF_W)) u_pte_chk (
        .pte      (mem_rsp_data),
        .is_write (wr_q),
        .offset   (va_off),
        .fault    (pte_fault),
        .paddr    (pte_paddr)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state_q <= ST_IDLE;
        else
            state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (req_valid) state_d = ST_CHECK;
            ST_CHECK: state_d = (seg_fault != FLT_NONE) ? ST_DONE : ST_ISSUE;
            ST_ISSUE: if (mem_req_ready) state_d = ST_WAIT;
            ST_WAIT:  if (mem_rsp_valid) state_d = ST_DONE;
            ST_DONE:  if (rsp_ready) state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    // handshake outputs
    always_comb begin
        req_ready     = 1'b0;
        mem_req_valid = 1'b0;
        rsp_valid     = 1'b0;
        unique case (state_q)
            ST_IDLE:  req_ready     = 1'b1;
            ST_ISSUE: mem_req_valid = 1'b1;
            ST_DONE:  rsp_valid     = 1'b1;
            default:  ;
        endcase
    end

    // datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            va_q       <= '0;
            wr_q       <= 1'b0;
            pte_addr_q <= '0;
            paddr_q    <= '0;
            fault_q    <= FLT_NONE;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    if (req_valid) begin
                        va_q <= req_vaddr;
                        wr_q <= req_write;
                    end
                end
                ST_CHECK: begin
                    fault_q    <= seg_fault;
                    paddr_q    <= '0;
                    pte_addr_q <= seg_pte_addr;
                end
                ST_WAIT: begin
                    if (mem_rsp_valid) begin
                        fault_q <= pte_fault;
                        paddr_q <= (pte_fault == FLT_NONE) ? pte_paddr : '0;
                    end
                end
                default: ;
            endcase
        end
    end

    assign mem_req_addr = pte_addr_q;
    assign rsp_paddr    = paddr_q;
    assign rsp_fault    = fault_q;

endmodule

// File: rtl/pst_checker.sv
module pst_checker #(
    parameter int VA_W  = 32,
    parameter int OFF_W = 12,
    parameter int AW    = 32,
    parameter int DW    = 32
) (
    input logic            clk,
    input logic            rst_n,
    input logic            req_valid,
    input logic            req_ready,
    input logic [VA_W-1:0] req_vaddr,
    input logic            mem_req_valid,
    input logic            mem_req_ready,
    input logic [AW-1:0]   mem_req_addr,
    input logic            rsp_valid,
    input logic            rsp_ready,
    input logic [DW-1:0]   rsp_paddr,
    input logic [1:0]      rsp_fault
);
    logic [OFF_W-1:0] off_q;
    logic             read_seen;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            off_q     <= '0;
            read_seen <= 1'b0;
        end else if (req_valid && req_ready) begin
            off_q     <= req_vaddr[OFF_W-1:0];
            read_seen <= 1'b0;
        end else if (mem_req_valid && mem_req_ready) begin
            read_seen <= 1'b1;
        end
    end

    assert_rsp_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_paddr) && $stable(rsp_fault));

    assert_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid || mem_req_valid) |-> !req_ready);

    assert_mreq_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr));

    assert_fault_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid && rsp_fault != 2'd0 |-> rsp_paddr == '0);

    assert_offset_R8: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid && rsp_fault == 2'd0 |-> rsp_paddr[OFF_W-1:0] == off_q);

    assert_no_read_R3: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid && rsp_fault == 2'd1 |-> !read_seen);

    assert_read_done_R5: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid && rsp_fault == 2'd0 |-> read_seen);

endmodule

bind pst_translator pst_checker #(
    .VA_W(VA_W), .OFF_W(OFF_W), .AW(AW), .DW(DW)
) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .req_valid     (req_valid),
    .req_ready     (req_ready),
    .req_vaddr     (req_vaddr),
    .mem_req_valid (mem_req_valid),
    .mem_req_ready (mem_req_ready),
    .mem_req_addr  (mem_req_addr),
    .rsp_valid     (rsp_valid),
    .rsp_ready     (rsp_ready),
    .rsp_paddr     (rsp_paddr),
    .rsp_fault     (rsp_fault)
);

// File: tb/test_pst_translator.sv
module test_pst_translator;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [3:0]  cfg_idx = '0;
    logic [31:0] cfg_base = '0;
    logic [16:0] cfg_len = '0;
    logic        cfg_wr_ok = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [31:0] req_vaddr = '0;
    logic        req_write = 1'b0;
    logic        mem_req_valid;
    logic        mem_req_ready = 1'b0;
    logic [31:0] mem_req_addr;
    logic        mem_rsp_valid = 1'b0;
    logic [31:0] mem_rsp_data = '0;
    logic        rsp_valid;
    logic        rsp_ready = 1'b0;
    logic [31:0] rsp_paddr;
    logic [1:0]  rsp_fault;

    always #(CLK_PERIOD/2) clk = ~clk;

    pst_translator i_pst_translator (
        .clk(clk), .rst_n(rst_n),
        .cfg_we(cfg_we), .cfg_idx(cfg_idx), .cfg_base(cfg_base),
        .cfg_len(cfg_len), .cfg_wr_ok(cfg_wr_ok),
        .req_valid(req_valid), .req_ready(req_ready),
        .req_vaddr(req_vaddr), .req_write(req_write),
        .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
        .mem_req_addr(mem_req_addr),
        .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data),
        .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
        .rsp_paddr(rsp_paddr), .rsp_fault(rsp_fault)
    );

    int checks = 0;
    int failures = 0;
    bit finished = 0;

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, exp);
        end
    endtask

    task automatic report();
        if (!finished) begin
            finished = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    endtask

    // memory model and bench copy of the segment table
    logic [31:0] mem [1024];
    logic [31:0] sb_base [16];
    logic [16:0] sb_len  [16];
    bit          sb_rw   [16];

    typedef struct {
        logic [1:0]  f;
        logic [31:0] pa;
        string       tag;
    } exp_t;
    exp_t        exp_q[$];
    logic [31:0] addr_q[$];
    int          exp_reads = 0;
    int          nreads = 0;

    task automatic cfg(input int idx, input logic [31:0] base, input logic [16:0] len, input bit rw);
        @(negedge clk);
        cfg_we = 1; cfg_idx = 4'(idx); cfg_base = base; cfg_len = len; cfg_wr_ok = rw;
        @(negedge clk);
        cfg_we = 0;
        sb_base[idx] = base; sb_len[idx] = len; sb_rw[idx] = rw;
    endtask

    // driver: computes the expected outcome from the requirements, then offers the request
    task automatic send(input logic [31:0] va, input bit w, input string tag_in = "");
        exp_t e;
        logic [3:0]  seg;
        logic [15:0] pg;
        logic [31:0] a, pte;
        seg = va[31:28]; pg = va[27:12];   // R1 field split
        e.pa = '0;
        if ({1'b0, pg} >= sb_len[seg]) begin
            e.f = 2'd1; e.tag = "R3";
        end else if (w && !sb_rw[seg]) begin
            e.f = 2'd2; e.tag = "R4";
        end else begin
            a = sb_base[seg] + {14'd0, pg, 2'b00};
            addr_q.push_back(a);
            exp_reads++;
            pte = mem[a[11:2]];
            if (!pte[1]) begin
                e.f = 2'd3; e.tag = "R6";
            end else if (w && !pte[0]) begin
                e.f = 2'd2; e.tag = "R7";
            end else begin
                e.f = 2'd0; e.tag = "R8";
                e.pa = {pte[31:12], va[11:0]};
            end
        end
        if (tag_in != "") e.tag = tag_in;
        exp_q.push_back(e);
        @(negedge clk);
        req_vaddr = va; req_write = w; req_valid = 1;
        while (!req_ready) @(negedge clk);
        @(negedge clk);
        req_valid = 0;
    endtask

    task automatic drain();
        while (exp_q.size() != 0) @(negedge clk);
        repeat (3) @(negedge clk);
    endtask

    // memory responder: varied ready and latency
    initial begin
        int  mcyc = 0;
        bit  pend = 0;
        int  pdelay = 0;
        logic [9:0] pidx = '0;
        bit  mheld = 0;
        logic [31:0] maddr = '0;
        forever begin
            @(negedge clk);
            mcyc++;
            mem_rsp_valid = 0;
            if (pend) begin
                if (pdelay == 0) begin
                    mem_rsp_valid = 1;
                    mem_rsp_data  = mem[pidx];
                    pend = 0;
                end else pdelay--;
            end
            if (mheld) begin
                check(mem_req_valid && mem_req_addr == maddr, "R12", mem_req_addr, maddr);
                mheld = 0;
            end
            mem_req_ready = (mcyc % 3 != 1);
            if (mem_req_valid && mem_req_ready) begin
                logic [31:0] ea;
                ea = (addr_q.size() != 0) ? addr_q.pop_front() : 32'hDEAD_BEEF;
                check(mem_req_addr == ea, "R5", mem_req_addr, ea);
                pend = 1; pidx = mem_req_addr[11:2]; pdelay = nreads % 3;
                nreads++;
            end else if (mem_req_valid) begin
                mheld = 1; maddr = mem_req_addr;
            end
        end
    end

    // monitor: pops the scoreboard on each accepted result
    initial begin
        int  cyc = 0;
        bit  held = 0;
        logic [31:0] hp = '0;
        logic [1:0]  hf = '0;
        forever begin
            @(negedge clk);
            cyc++;
            if (rsp_valid)
                check(!req_ready, "R10", {31'd0, req_ready}, 32'd0);
            if (held) begin
                check(rsp_valid && rsp_paddr == hp && rsp_fault == hf, "R10", rsp_paddr, hp);
                held = 0;
            end
            rsp_ready = (cyc % 4 != 3);
            if (rsp_valid && rsp_ready) begin
                exp_t e;
                if (exp_q.size() == 0) begin
                    check(0, "R10", {30'd0, rsp_fault}, 32'hFFFF_FFFF);
                end else begin
                    e = exp_q.pop_front();
                    check(rsp_fault == e.f, e.tag, {30'd0, rsp_fault}, {30'd0, e.f});
                    check(rsp_paddr == e.pa, e.tag, rsp_paddr, e.pa);
                    if (e.f != 2'd0)
                        check(rsp_paddr == 32'd0, "R9", rsp_paddr, 32'd0);
                end
            end else if (rsp_valid) begin
                held = 1; hp = rsp_paddr; hf = rsp_fault;
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired actual=busy expected=done");
        report();
    end

    initial begin
        int snap;
        for (int i = 0; i < 1024; i++)
            mem[i] = {20'(i * 19 + 32'h50), 10'd0, (i % 5 != 0), (i % 3 != 0)};
        for (int i = 0; i < 16; i++) begin
            sb_base[i] = '0; sb_len[i] = '0; sb_rw[i] = 0;
        end

        repeat (3) @(negedge clk);
        // R11 reset state
        check(req_ready == 1'b1, "R11", {31'd0, req_ready}, 32'd1);
        check(rsp_valid == 1'b0, "R11", {31'd0, rsp_valid}, 32'd0);
        check(mem_req_valid == 1'b0, "R11", {31'd0, mem_req_valid}, 32'd0);
        rst_n = 1;
        @(negedge clk);
        send(32'h0000_0123, 0, "R11");
        drain();
        check(nreads == 0, "R11", nreads, 0);

        cfg(0, 32'h0000_0000, 17'd16, 1);
        cfg(1, 32'h0000_0100, 17'd8, 0);
        cfg(2, 32'h0000_0200, 17'd0, 1);
        cfg(3, 32'h0000_0300, 17'h10000, 1);

        // sweep segment 0 past its length, mixed access and offsets
        for (int p = 0; p <= 17; p++)
            send({4'h0, 16'(p), 12'(p * 32'h111)}, p[0]);
        // read-only segment: reads go through to the page entry
        for (int p = 0; p <= 8; p++)
            send({4'h1, 16'(p), 12'hABC}, 0);
        drain();

        // R4: segment-level permission fault makes no read
        snap = nreads;
        send({4'h1, 16'd2, 12'h010}, 1);
        drain();
        check(nreads == snap, "R4", nreads, snap);
        // R4 precedence: bounds before segment permission
        send({4'h1, 16'd8, 12'h010}, 1, "R4");
        // R3: empty segment, unconfigured segment
        snap = nreads;
        send({4'h2, 16'd0, 12'h000}, 0);
        send({4'h9, 16'd1, 12'hFFF}, 1);
        drain();
        check(nreads == snap, "R3", nreads, snap);

        // full-size segment, largest page number
        send({4'h3, 16'hFFFF, 12'h5A5}, 0);
        send({4'h3, 16'hFFFF, 12'h5A5}, 1);
        send({4'h3, 16'h0003, 12'h001}, 1);
        drain();

        // R2: reprogramming changes outcomes of the same address
        cfg(1, 32'h0000_0100, 17'd8, 1);
        send({4'h1, 16'd2, 12'h010}, 1, "R2");
        cfg(0, 32'h0000_0000, 17'd4, 1);
        send({4'h0, 16'd4, 12'h044}, 0, "R2");
        cfg(0, 32'h0000_0040, 17'd4, 1);
        send({4'h0, 16'd1, 12'h077}, 0, "R2");
        drain();

        check(nreads == exp_reads, "R5", nreads, exp_reads);
        check(addr_q.size() == 0, "R5", addr_q.size(), 0);
        report();
    end

endmodule